// File: doc/BRIEF.md
# Voice Packet Assembler and Filter

This block frames and unframes the 5-byte voice packets carried over a shared serial line. On the send side it waits until the outgoing sample buffer holds a full packet's worth of samples, which is four bytes. It copies those four samples into a local hold store, puts a header byte built from the station switches in front of them, and hands the five bytes one at a time to the serial transmitter. If the transmitter reports that it lost the line to another station, the block sends the same packet again, starting from the header. It does not fetch the samples again.

On the receive side it takes bytes from the serial receiver and treats the first byte of each packet as a header. It writes the four bytes that follow into the incoming sample buffer, one write per byte, but only when the header names this station as the destination and does not name it as the sender. When the line goes quiet in the middle of a packet for more than two byte times, the part of the packet already received is dropped. The next byte is then read as a new header.

Top module: `vpkt_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `tx_valid`, `obuf_rd` and `ib_we` are all low.
- R2: A send does not begin, and no byte is popped from the outgoing buffer, while `obuf_count` is below 4.
- R3: A send pops exactly 4 bytes. It then presents the header {cfg_ctrl in bits 7:6, cfg_dest in bits 5:3, cfg_station in bits 2:0}, followed by the 4 samples in the order they were popped.
- R4: A byte on `tx_data` counts as taken only in a cycle where `tx_valid` and `tx_ready` are both high and `tx_collide` is low. While it waits, `tx_data` stays stable and `tx_valid` stays high.
- R5: When `tx_collide` is high during a send, the next byte offered is the header again, followed by the same 4 samples. No further pops happen.
- R6: When `tx_collide` and `tx_ready` are both high in the cycle the last sample is offered, that packet is not complete. The whole packet is offered again.
- R7: A received header whose bits 5:3 equal `cfg_station` and whose bits 2:0 differ from it causes the next 4 received bytes to be written in order to `ib_data`. Each write is pulsed on `ib_we` in the cycle after that byte's `rx_valid`.
- R8: A received header whose bits 5:3 differ from `cfg_station` causes no writes for its 4 payload bytes. The byte after those 4 is read as a header.
- R9: A received header whose bits 2:0 equal `cfg_station` is ignored, even if its destination matches. Its 4 payload bytes cause no writes.
- R10: Inside a packet, a byte that arrives up to 2*BYTE_CYCLES cycles after the previous byte is still payload. If no byte arrives for longer than that, the partial packet is dropped and the next byte is read as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ctrl | input | 2 | Control field placed in sent headers |
| cfg_dest | input | 3 | Destination station placed in sent headers |
| cfg_station | input | 3 | This station's address (source field and receive match) |
| obuf_count | input | CNT_W | Bytes waiting in the outgoing buffer |
| obuf_data | input | 8 | Head byte of the outgoing buffer (shown before the pop) |
| obuf_rd | output | 1 | Pop one byte from the outgoing buffer |
| tx_data | output | 8 | Byte offered to the serial transmitter |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| tx_collide | input | 1 | Transmitter lost the shared line; the packet must be sent again |
| rx_data | input | 8 | Byte from the serial receiver |
| rx_valid | input | 1 | `rx_data` is valid for this cycle |
| ib_data | output | 8 | Payload byte for the incoming buffer |
| ib_we | output | 1 | Write strobe for the incoming buffer |

## Verification
Two events can land in the same cycle: a collision report and the transmitter taking a byte. In that cycle the collision must win. The bench makes this happen by raising `tx_collide` while `tx_ready` is held high, once in the middle of the packet and once exactly when the last sample is on `tx_data`. It then compares the full stream of taken bytes with an expected stream: the bytes taken before the collision, followed by one complete packet. It also checks that the outgoing buffer was popped only four times. If the last byte were counted as sent, the stream would be one packet short, and the check would report it.

// File: rtl/vpkt_pkg.sv
package vpkt_pkg;

    localparam int BYTE_W = 8;
    localparam int CTRL_W = 2;
    localparam int ADDR_W = 3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CTRL_W-1:0] ctrl_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Packed so that ctrl lands in [7:6], dest in [5:3], src in [2:0]
    typedef struct packed {
        ctrl_t ctrl;
        addr_t dest;
        addr_t src;
    } hdr_t;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_LOAD = 2'd1,
        TX_SEND = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_HDR = 1'b0,
        RX_PAY = 1'b1
    } rx_state_e;

    function automatic hdr_t build_header(ctrl_t c, addr_t d, addr_t s);
        hdr_t h;
        h.ctrl = c;
        h.dest = d;
        h.src  = s;
        return h;
    endfunction

    // Keep a packet only if it is addressed here and was not sent from here
    function automatic logic header_wanted(hdr_t h, addr_t me);
        return (h.dest == me) && (h.src != me);
    endfunction

endpackage

// File: rtl/vpkt_tx_assembler.sv
module vpkt_tx_assembler
    import vpkt_pkg::*;
#(
    parameter int SAMPLES = 4,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  hdr_t             cfg_hdr,
    input  logic [CNT_W-1:0] obuf_count,
    input  byte_t            obuf_data,
    output logic             obuf_rd,
    output byte_t            tx_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    input  logic             tx_collide
);

    localparam int IDX_W = $clog2(SAMPLES + 1);
    localparam int SEL_W = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;

    tx_state_e        state;
    logic [IDX_W-1:0] idx;
    hdr_t             hdr_q;
    byte_t            hold [SAMPLES];
    logic [SEL_W-1:0] sel;

    assign obuf_rd  = (state == TX_LOAD);
    assign tx_valid = (state == TX_SEND);
    assign sel      = SEL_W'(idx - IDX_W'(1));

    always_comb begin
        if (idx == '0) tx_data = byte_t'(hdr_q);
        else           tx_data = hold[sel];
    end

    // One capture register per sample slot
    for (genvar g = 0; g < SAMPLES; g++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst)
                hold[g] <= '0;
            else if (state == TX_LOAD && idx == IDX_W'(g))
                hold[g] <= obuf_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            idx   <= '0;
            hdr_q <= '0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (obuf_count >= CNT_W'(SAMPLES)) begin
                        state <= TX_LOAD;
                        idx   <= '0;
                        hdr_q <= cfg_hdr;
                    end
                end
                TX_LOAD: begin
                    if (idx == IDX_W'(SAMPLES - 1)) begin
                        state <= TX_SEND;
                        idx   <= '0;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                TX_SEND: begin
                    if (tx_collide) begin
                        idx <= '0;
                    end else if (tx_ready) begin
                        if (idx == IDX_W'(SAMPLES)) begin
                            state <= TX_IDLE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                default: begin
                    state <= TX_IDLE;
                    idx   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/vpkt_gap_timer.sv
module vpkt_gap_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic kick,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = run && !kick && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || kick || !run)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/vpkt_rx_filter.sv
module vpkt_rx_filter
    import vpkt_pkg::*;
#(
    parameter int SAMPLES   = 4,
    parameter int GAP_LIMIT = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  addr_t station,
    input  byte_t rx_data,
    input  logic  rx_valid,
    output byte_t ib_data,
    output logic  ib_we
);

    localparam int CW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;

    rx_state_e     state;
    logic [CW-1:0] cnt;
    logic          keep;
    logic          gap_expired;

    vpkt_gap_timer #(
        .LIMIT (GAP_LIMIT)
    ) i_gap (
        .clk     (clk),
        .rst     (rst),
        .run     (state == RX_PAY),
        .kick    (rx_valid),
        .expired (gap_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_HDR;
            cnt     <= '0;
            keep    <= 1'b0;
            ib_we   <= 1'b0;
            ib_data <= '0;
        end else begin
            ib_we <= 1'b0;
            unique case (state)
                RX_HDR: begin
                    if (rx_valid) begin
                        keep  <= header_wanted(hdr_t'(rx_data), station);
                        cnt   <= '0;
                        state <= RX_PAY;
                    end
                end
                RX_PAY: begin
                    if (rx_valid) begin
                        if (keep) begin
                            ib_we   <= 1'b1;
                            ib_data <= rx_data;
                        end
                        if (cnt == CW'(SAMPLES - 1)) begin
                            state <= RX_HDR;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end else if (gap_expired) begin
                        state <= RX_HDR;
                        cnt   <= '0;
                    end
                end
                default: state <= RX_HDR;
            endcase
        end
    end

endmodule

// File: rtl/vpkt_engine.sv
module vpkt_engine
    import vpkt_pkg::*;
#(
    parameter int SAMPLES     = 4,
    parameter int CNT_W       = 8,
    parameter int BYTE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_ctrl,
    input  logic [2:0]       cfg_dest,
    input  logic [2:0]       cfg_station,
    input  logic [CNT_W-1:0] obuf_count,
    input  logic [7:0]       obuf_data,
    output logic             obuf_rd,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    input  logic             tx_collide,
    input  logic [7:0]       rx_data,
    input  logic             rx_valid,
    output logic [7:0]       ib_data,
    output logic             ib_we
);

    localparam int GAP_LIMIT = 2 * BYTE_CYCLES;

    hdr_t cfg_hdr;

    assign cfg_hdr = build_header(cfg_ctrl, cfg_dest, cfg_station);

    vpkt_tx_assembler #(
        .SAMPLES (SAMPLES),
        .CNT_W   (CNT_W)
    ) i_tx (
        .clk        (clk),
        .rst        (rst),
        .cfg_hdr    (cfg_hdr),
        .obuf_count (obuf_count),
        .obuf_data  (obuf_data),
        .obuf_rd    (obuf_rd),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_collide (tx_collide)
    );

    vpkt_rx_filter #(
        .SAMPLES   (SAMPLES),
        .GAP_LIMIT (GAP_LIMIT)
    ) i_rx (
        .clk      (clk),
        .rst      (rst),
        .station  (cfg_station),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .ib_data  (ib_data),
        .ib_we    (ib_we)
    );

endmodule

// File: rtl/vpkt_checker.sv
module vpkt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] obuf_count,
    input logic             obuf_rd,
    input logic [7:0]       tx_data,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             tx_collide,
    input logic             rx_valid,
    input logic             ib_we
);

    logic rst_q;

    always_ff @(posedge clk) rst_q <= rst;

    // R1: quiet outputs in the first cycle after a reset cycle
    always_ff @(posedge clk) begin
        if (rst_q) begin
            a_r1_quiet_after_reset: assert (!tx_valid && !obuf_rd && !ib_we)
                else $error("R1 outputs active after reset");
        end
    end

    // R2: a fetch burst only begins with a full packet waiting
    a_r2_fetch_needs_full: assert property (@(posedge clk) disable iff (rst)
        $rose(obuf_rd) |-> (obuf_count >= CNT_W'(4)));

    // R4: an offered byte holds until taken
    a_r4_hold_byte: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !tx_collide) |=> (tx_valid && $stable(tx_data)));

    // R5: a collision restarts the send without another fetch
    a_r5_no_refetch: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_collide) |=> (tx_valid && !obuf_rd));

    // R7: every buffer write follows a received byte
    a_r7_write_follows_byte: assert property (@(posedge clk) disable iff (rst)
        ib_we |-> $past(rx_valid));

endmodule

bind vpkt_engine vpkt_checker #(.CNT_W(CNT_W)) i_vpkt_checker (.*);

// File: tb/test_vpkt_engine.sv
`timescale 1ns/1ps
module test_vpkt_engine;

    localparam int SAMPLES     = 4;
    localparam int CNT_W       = 8;
    localparam int BYTE_CYCLES = 4;
    localparam int GAP         = 2 * BYTE_CYCLES;

    logic             clk = 1'b0;
    logic             rst;
    logic [1:0]       cfg_ctrl;
    logic [2:0]       cfg_dest;
    logic [2:0]       cfg_station;
    logic [CNT_W-1:0] obuf_count;
    logic [7:0]       obuf_data;
    logic             obuf_rd;
    logic [7:0]       tx_data;
    logic             tx_valid;
    logic             tx_ready;
    logic             tx_collide;
    logic [7:0]       rx_data;
    logic             rx_valid;
    logic [7:0]       ib_data;
    logic             ib_we;

    always #2 clk = ~clk;

    vpkt_engine #(
        .SAMPLES     (SAMPLES),
        .CNT_W       (CNT_W),
        .BYTE_CYCLES (BYTE_CYCLES)
    ) i_vpkt_engine (
        .clk         (clk),
        .rst         (rst),
        .cfg_ctrl    (cfg_ctrl),
        .cfg_dest    (cfg_dest),
        .cfg_station (cfg_station),
        .obuf_count  (obuf_count),
        .obuf_data   (obuf_data),
        .obuf_rd     (obuf_rd),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_collide  (tx_collide),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .ib_data     (ib_data),
        .ib_we       (ib_we)
    );

    // Outgoing buffer model
    logic [7:0] omem [256];
    logic [7:0] wp;
    logic [7:0] rp;
    assign obuf_count = wp - rp;
    assign obuf_data  = omem[rp];

    always @(posedge clk) begin
        if (rst) rp <= 8'd0;
        else if (obuf_rd) rp <= rp + 8'd1;
    end

    // Logs of taken bytes and buffer writes
    logic [7:0] txlog [256];
    logic [7:0] iblog [256];
    int txn = 0;
    int ibn = 0;

    always @(posedge clk) begin
        if (!rst && tx_valid && tx_ready && !tx_collide) begin
            txlog[txn[7:0]] <= tx_data;
            txn <= txn + 1;
        end
        if (!rst && ib_we) begin
            iblog[ibn[7:0]] <= ib_data;
            ibn <= ibn + 1;
        end
    end

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic push_sample(input logic [7:0] b);
        omem[wp] = b;
        wp = wp + 8'd1;
    endtask

    task automatic wait_txn(input int target);
        for (int i = 0; i < 300 && txn < target; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_packet(input string tag, input int base, input logic [7:0] hdr,
                                input logic [7:0] s0, input logic [7:0] s1,
                                input logic [7:0] s2, input logic [7:0] s3);
        chk({tag, " header"}, 32'(txlog[base[7:0]]), 32'(hdr));
        chk({tag, " sample0"}, 32'(txlog[8'(base + 1)]), 32'(s0));
        chk({tag, " sample1"}, 32'(txlog[8'(base + 2)]), 32'(s1));
        chk({tag, " sample2"}, 32'(txlog[8'(base + 3)]), 32'(s2));
        chk({tag, " sample3"}, 32'(txlog[8'(base + 4)]), 32'(s3));
    endtask

    task automatic send_rx(input logic [7:0] b);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_rx_packet(input logic [7:0] h, input logic [7:0] p0,
                                  input logic [7:0] p1, input logic [7:0] p2,
                                  input logic [7:0] p3);
        send_rx(h);
        send_rx(p0);
        send_rx(p1);
        send_rx(p2);
        send_rx(p3);
    endtask

    // ---------------- scenarios ----------------

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 tx_valid in reset", 32'(tx_valid), 32'd0);
        chk("R1 obuf_rd in reset", 32'(obuf_rd), 32'd0);
        chk("R1 ib_we in reset", 32'(ib_we), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after reset", 32'({tx_valid, obuf_rd, ib_we}), 32'd0);
    endtask

    task automatic test_threshold();
        int base;
        base = txn;
        cfg_ctrl = 2'b10; cfg_dest = 3'd5; cfg_station = 3'd2;
        push_sample(8'h11); push_sample(8'h22); push_sample(8'h33);
        repeat (20) @(negedge clk);
        chk("R2 nothing sent below four", 32'(txn - base), 32'd0);
        chk("R2 nothing popped below four", 32'(obuf_count), 32'd3);
        push_sample(8'h44);
        wait_txn(base + 5);
        chk("R3 byte count", 32'(txn - base), 32'd5);
        chk("R3 four pops", 32'(obuf_count), 32'd0);
        check_packet("R3", base, {2'b10, 3'd5, 3'd2}, 8'h11, 8'h22, 8'h33, 8'h44);
    endtask

    task automatic test_stall();
        int base;
        base = txn;
        cfg_ctrl = 2'b01; cfg_dest = 3'd3; cfg_station = 3'd2;
        tx_ready = 1'b0;
        push_sample(8'hC1); push_sample(8'hC2); push_sample(8'hC3); push_sample(8'hC4);
        for (int i = 0; i < 40; i++) begin
            tx_ready = (i % 3 == 2);
            @(negedge clk);
        end
        tx_ready = 1'b1;
        wait_txn(base + 5);
        chk("R4 exactly five bytes under stalls", 32'(txn - base), 32'd5);
        check_packet("R4", base, {2'b01, 3'd3, 3'd2}, 8'hC1, 8'hC2, 8'hC3, 8'hC4);
    endtask

    task automatic test_collide(input string tag, input int k);
        int base;
        base = txn;
        cfg_ctrl = 2'b11; cfg_dest = 3'd6; cfg_station = 3'd2;
        tx_ready = 1'b1;
        push_sample(8'h5A); push_sample(8'h6B); push_sample(8'h7C); push_sample(8'h8D);
        for (int i = 0; i < 50 && !tx_valid; i++) @(negedge clk);
        repeat (k) @(negedge clk);
        tx_collide = 1'b1;
        @(negedge clk);
        tx_collide = 1'b0;
        wait_txn(base + k + 5);
        chk({tag, " total taken"}, 32'(txn - base), 32'(k + 5));
        chk({tag, " first byte before collision"}, 32'(txlog[base[7:0]]),
            32'({2'b11, 3'd6, 3'd2}));
        check_packet(tag, base + k, {2'b11, 3'd6, 3'd2}, 8'h5A, 8'h6B, 8'h7C, 8'h8D);
        chk({tag, " no refetch"}, 32'(obuf_count), 32'd0);
    endtask

    task automatic test_rx_accept();
        int base;
        base = ibn;
        cfg_station = 3'd2;
        // dest 2, src 5
        send_rx_packet({2'b00, 3'd2, 3'd5}, 8'hA1, 8'hA2, 8'hA3, 8'hA4);
        repeat (3) @(negedge clk);
        chk("R7 four writes", 32'(ibn - base), 32'd4);
        chk("R7 payload0", 32'(iblog[base[7:0]]), 32'hA1);
        chk("R7 payload1", 32'(iblog[8'(base + 1)]), 32'hA2);
        chk("R7 payload2", 32'(iblog[8'(base + 2)]), 32'hA3);
        chk("R7 payload3", 32'(iblog[8'(base + 3)]), 32'hA4);
    endtask

    task automatic test_rx_other_dest();
        int base;
        base = ibn;
        send_rx_packet({2'b01, 3'd6, 3'd5}, 8'hB1, 8'hB2, 8'hB3, 8'hB4);
        repeat (3) @(negedge clk);
        chk("R8 no writes for other destination", 32'(ibn - base), 32'd0);
        send_rx_packet({2'b01, 3'd2, 3'd6}, 8'hB5, 8'hB6, 8'hB7, 8'hB8);
        repeat (3) @(negedge clk);
        chk("R8 framing kept after filtered packet", 32'(ibn - base), 32'd4);
        chk("R8 next packet first payload", 32'(iblog[base[7:0]]), 32'hB5);
    endtask

    task automatic test_rx_own_source();
        int base;
        base = ibn;
        send_rx_packet({2'b10, 3'd2, 3'd2}, 8'hE1, 8'hE2, 8'hE3, 8'hE4);
        repeat (3) @(negedge clk);
        chk("R9 own source ignored", 32'(ibn - base), 32'd0);
    endtask

    task automatic test_rx_gap();
        int base;
        base = ibn;
        // Longest allowed gap: byte arrives GAP cycles after the previous
        send_rx({2'b00, 3'd2, 3'd1});
        send_rx(8'hD1);
        repeat (GAP - 1) @(negedge clk);
        send_rx(8'hD2); send_rx(8'hD3); send_rx(8'hD4);
        repeat (3) @(negedge clk);
        chk("R10 boundary gap kept", 32'(ibn - base), 32'd4);
        chk("R10 boundary gap last byte", 32'(iblog[8'(base + 3)]), 32'hD4);
        base = ibn;
        // Gap too long: partial packet dropped, next byte is a header
        send_rx({2'b00, 3'd2, 3'd1});
        send_rx(8'hF1);
        send_rx(8'hF2);
        repeat (GAP + 3) @(negedge clk);
        send_rx_packet({2'b00, 3'd2, 3'd4}, 8'h91, 8'h92, 8'h93, 8'h94);
        repeat (3) @(negedge clk);
        chk("R10 writes after timeout", 32'(ibn - base), 32'd6);
        chk("R10 new header not written", 32'(iblog[8'(base + 2)]), 32'h91);
        chk("R10 last payload", 32'(iblog[8'(base + 5)]), 32'h94);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) omem[i] = 8'h00;
        wp = 8'd0;
        rst = 1'b1;
        cfg_ctrl = 2'b00; cfg_dest = 3'd0; cfg_station = 3'd2;
        tx_ready = 1'b1; tx_collide = 1'b0;
        rx_data = 8'h00; rx_valid = 1'b0;
        @(negedge clk);
        test_reset();
        test_threshold();
        test_stall();
        test_collide("R5 mid-packet collision", 2);
        test_collide("R6 collision on last byte", 4);
        test_rx_accept();
        test_rx_other_dest();
        test_rx_own_source();
        test_rx_gap();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule